// File: doc/BRIEF.md
# Configuration Request PIO Engine

This block lets a host processor issue one configuration read or write at a time toward a downstream link without assembling packets itself. Software fills a small bank of 32-bit registers with a transaction kind, a packed target address (bus, device, function, register), write data and byte-lane strobes. It then writes one to a start register. The engine captures a snapshot of those fields and offers them as a single request on a valid/ready port.

Once the downstream side accepts the request, the engine waits for exactly one completion on a second valid/ready port. It records the three-bit completion status and, for read kinds only, the returned data word. It then drops the start indication and raises a sticky done flag, which software clears by writing one. A maskable interrupt output follows the done flag.

Back-pressure rules: the request port holds `req_valid` and every request field steady until a cycle in which `req_ready` is high, and it never withdraws an offered request. The completion port raises `cpl_ready` only while a request is outstanding, so a completion offered at any other time simply waits.

Top module: `cfg_pio_engine`

## Requirements
- R1: After reset the start register reads 0, the done flag reads 0, the interrupt mask bit reads 1, `irq` is 0 and `req_valid` is 0.
- R2: Writing 1 to bit 0 of the start register (offset 0x1C) while idle raises `req_valid` on the next cycle. The request carries the stored kind, address high, write data and bypass bit. The start register reads 1 until the completion is accepted.
- R3: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and all request fields hold their values. Each start produces exactly one accepted request.
- R4: The address on the request port equals the programmed low address word (offset 0x08) with bits [1:0] forced to zero. The packed fields are bus at [27:20], device at [19:15], function at [14:12] and dword register offset at [11:2].
- R5: For read kinds 0x8 (type-0) and 0x9 (type-1), `req_strb` is 0xF whatever the strobe register (offset 0x14) holds. For any other kind, `req_strb` is the programmed four-bit strobe.
- R6: `cpl_ready` is high only after the request is accepted and before a completion is taken. On acceptance the start register reads 0, status bits [9:7] (offset 0x04) hold `cpl_status` (0 success, 1 unsupported, 2 retry, 4 abort) and the done flag (bit 0 of offset 0x20) reads 1.
- R7: The read-data register (offset 0x18) is loaded with `cpl_data` only for read kinds 0x8 and 0x9. A completion of any other kind leaves it unchanged.
- R8: Status bit 0 reads 1 when the launched kind is a configuration kind (0x8 to 0xB, non-posted) and 0 otherwise.
- R9: A write of 1 to start while a request is outstanding is ignored and no second request appears.
- R10: The done flag is cleared only by writing 1 to bit 0 of offset 0x20. Writing 0 there leaves it set.
- R11: `irq` equals the done flag AND NOT bit 0 of the mask register (offset 0x24).
- R12: The control register (offset 0x00) stores only the kind in bits [3:0] and the window-bypass bit 24, reading 0 elsewhere. The bypass bit appears on `req_win_bypass`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr`, combinational |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Downstream accepts request |
| req_kind | output | 4 | Transaction kind code |
| req_addr_lo | output | 32 | Packed configuration address, bits [1:0] zero |
| req_addr_hi | output | 32 | Upper address word |
| req_wdata | output | 32 | Write data, already lane-shifted by software |
| req_strb | output | 4 | Byte-lane enables |
| req_win_bypass | output | 1 | Address window bypass flag |
| cpl_valid | input | 1 | Completion offered |
| cpl_ready | output | 1 | Engine accepts completion |
| cpl_status | input | 3 | Completion status code |
| cpl_data | input | 32 | Completion read data |
| irq | output | 1 | Unmasked done interrupt |

## Verification
The bench builds the engine with `ADDR_W` set to 6, the narrowest offset bus that still reaches the interrupt mask at 0x24. Every register decode is therefore exercised at its tightest width. The downstream stub is tuned for each case with a ready stall length and a completion latency. Long stalls bring field stability under back-pressure within reach, and long latencies leave room to hit the start register while a request is outstanding. A mix of read, write and non-configuration kinds covers every status code and the read-data retention rule.

// File: rtl/cfg_pio_pkg.sv
package cfg_pio_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;
  localparam int unsigned CST_W  = 3;
  localparam int unsigned KIND_W = 4;

  localparam int unsigned OFS_CTRL  = 'h00;
  localparam int unsigned OFS_STAT  = 'h04;
  localparam int unsigned OFS_ALO   = 'h08;
  localparam int unsigned OFS_AHI   = 'h0C;
  localparam int unsigned OFS_WDAT  = 'h10;
  localparam int unsigned OFS_STRB  = 'h14;
  localparam int unsigned OFS_RDAT  = 'h18;
  localparam int unsigned OFS_START = 'h1C;
  localparam int unsigned OFS_ISR   = 'h20;
  localparam int unsigned OFS_MASK  = 'h24;

  localparam int unsigned BYPASS_BIT = 24;
  localparam int unsigned CST_LSB    = 7;

  localparam logic [KIND_W-1:0] KIND_RD_T0 = 4'h8;
  localparam logic [KIND_W-1:0] KIND_RD_T1 = 4'h9;
  localparam logic [KIND_W-1:0] KIND_WR_T0 = 4'hA;
  localparam logic [KIND_W-1:0] KIND_WR_T1 = 4'hB;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic              bypass;
    logic [WORD_W-1:0] addr_lo;
    logic [WORD_W-1:0] addr_hi;
    logic [WORD_W-1:0] wdata;
    logic [LANES-1:0]  strb;
  } pio_req_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT} pio_state_e;

  function automatic logic kind_is_read(input logic [KIND_W-1:0] k);
    return (k == KIND_RD_T0) || (k == KIND_RD_T1);
  endfunction

  function automatic logic kind_is_cfg(input logic [KIND_W-1:0] k);
    return (k == KIND_RD_T0) || (k == KIND_RD_T1) ||
           (k == KIND_WR_T0) || (k == KIND_WR_T1);
  endfunction
endpackage

// File: rtl/cfg_pio_regs.sv
module cfg_pio_regs
  import cfg_pio_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   wdata,
  output logic [WORD_W-1:0]   rdata,
  input  logic                busy,
  input  logic                done,
  input  logic [CST_W-1:0]    cst,
  input  logic                np,
  input  logic [WORD_W-1:0]   rd_word,
  output pio_req_t            prog,
  output logic                mask,
  output logic                start_wr,
  output logic                isr_wr
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign start_wr = wr_en && hit(addr, OFS_START);
  assign isr_wr   = wr_en && hit(addr, OFS_ISR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog <= '0;
      mask <= 1'b1;
    end else if (wr_en) begin
      if (hit(addr, OFS_CTRL)) begin
        prog.kind   <= wdata[KIND_W-1:0];
        prog.bypass <= wdata[BYPASS_BIT];
      end
      if (hit(addr, OFS_ALO))  prog.addr_lo <= wdata;
      if (hit(addr, OFS_AHI))  prog.addr_hi <= wdata;
      if (hit(addr, OFS_WDAT)) prog.wdata   <= wdata;
      if (hit(addr, OFS_STRB)) prog.strb    <= wdata[LANES-1:0];
      if (hit(addr, OFS_MASK)) mask         <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    if (hit(addr, OFS_CTRL)) begin
      rdata[KIND_W-1:0]  = prog.kind;
      rdata[BYPASS_BIT]  = prog.bypass;
    end
    if (hit(addr, OFS_STAT)) begin
      rdata[CST_LSB +: CST_W] = cst;
      rdata[0]                = np;
    end
    if (hit(addr, OFS_ALO))   rdata = prog.addr_lo;
    if (hit(addr, OFS_AHI))   rdata = prog.addr_hi;
    if (hit(addr, OFS_WDAT))  rdata = prog.wdata;
    if (hit(addr, OFS_STRB))  rdata[LANES-1:0] = prog.strb;
    if (hit(addr, OFS_RDAT))  rdata = rd_word;
    if (hit(addr, OFS_START)) rdata[0] = busy;
    if (hit(addr, OFS_ISR))   rdata[0] = done;
    if (hit(addr, OFS_MASK))  rdata[0] = mask;
  end
endmodule

// File: rtl/cfg_pio_shape.sv
module cfg_pio_shape
  import cfg_pio_pkg::*;
(
  input  pio_req_t snap,
  output pio_req_t shaped
);
  logic rd_kind;
  assign rd_kind = kind_is_read(snap.kind);

  assign shaped.kind    = snap.kind;
  assign shaped.bypass  = snap.bypass;
  assign shaped.addr_hi = snap.addr_hi;
  assign shaped.wdata   = snap.wdata;
  assign shaped.addr_lo = {snap.addr_lo[WORD_W-1:2], 2'b00};

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    assign shaped.strb[ln] = rd_kind | snap.strb[ln];
  end
endmodule

// File: rtl/cfg_pio_seq.sv
module cfg_pio_seq
  import cfg_pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_wr,
  input  logic              isr_wr,
  input  logic              wbit0,
  input  pio_req_t          prog,
  output pio_req_t          snap,
  output logic              send,
  input  logic              req_ready,
  input  logic              cpl_valid,
  output logic              cpl_take,
  input  logic [CST_W-1:0]  cpl_status,
  input  logic [WORD_W-1:0] cpl_data,
  output logic              busy,
  output logic              done,
  output logic [CST_W-1:0]  cst,
  output logic              np,
  output logic [WORD_W-1:0] rd_word
);
  pio_state_e st;
  logic       cpl_hs;

  assign send     = (st == ST_SEND);
  assign cpl_take = (st == ST_WAIT);
  assign busy     = (st != ST_IDLE);
  assign cpl_hs   = cpl_take && cpl_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      snap    <= '0;
      cst     <= '0;
      np      <= 1'b0;
      rd_word <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start_wr && wbit0) begin
          snap <= prog;
          np   <= kind_is_cfg(prog.kind);
          st   <= ST_SEND;
        end
        ST_SEND: if (req_ready) st <= ST_WAIT;
        ST_WAIT: if (cpl_valid) begin
          cst <= cpl_status;
          if (kind_is_read(snap.kind)) rd_word <= cpl_data;
          st  <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                done <= 1'b0;
    else if (cpl_hs)           done <= 1'b1;
    else if (isr_wr && wbit0)  done <= 1'b0;
  end
endmodule

// File: rtl/cfg_pio_engine.sv
module cfg_pio_engine
  import cfg_pio_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [3:0]        req_kind,
  output logic [31:0]       req_addr_lo,
  output logic [31:0]       req_addr_hi,
  output logic [31:0]       req_wdata,
  output logic [3:0]        req_strb,
  output logic              req_win_bypass,
  input  logic              cpl_valid,
  output logic              cpl_ready,
  input  logic [2:0]        cpl_status,
  input  logic [31:0]       cpl_data,
  output logic              irq
);
  pio_req_t          prog, snap, shaped;
  logic              mask, start_wr, isr_wr, busy, done, np;
  logic [CST_W-1:0]  cst;
  logic [WORD_W-1:0] rd_word;

  cfg_pio_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .busy(busy), .done(done),
    .cst(cst), .np(np), .rd_word(rd_word), .prog(prog), .mask(mask),
    .start_wr(start_wr), .isr_wr(isr_wr)
  );

  cfg_pio_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .isr_wr(isr_wr),
    .wbit0(bus_wdata[0]), .prog(prog), .snap(snap), .send(req_valid),
    .req_ready(req_ready), .cpl_valid(cpl_valid), .cpl_take(cpl_ready),
    .cpl_status(cpl_status), .cpl_data(cpl_data), .busy(busy),
    .done(done), .cst(cst), .np(np), .rd_word(rd_word)
  );

  cfg_pio_shape u_shape (.snap(snap), .shaped(shaped));

  assign req_kind       = shaped.kind;
  assign req_addr_lo    = shaped.addr_lo;
  assign req_addr_hi    = shaped.addr_hi;
  assign req_wdata      = shaped.wdata;
  assign req_strb       = shaped.strb;
  assign req_win_bypass = shaped.bypass;
  assign irq            = done & ~mask;
endmodule

// File: rtl/cfg_pio_checker.sv
module cfg_pio_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [3:0]  req_kind,
  input logic [31:0] req_addr_lo,
  input logic [31:0] req_addr_hi,
  input logic [31:0] req_wdata,
  input logic [3:0]  req_strb,
  input logic        req_win_bypass,
  input logic        cpl_ready
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid &&
      $stable({req_kind, req_addr_lo, req_addr_hi, req_wdata, req_strb, req_win_bypass})));

  assert_one_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);

  assert_cpl_after_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !cpl_ready);

  assert_dword_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr_lo[1:0] == 2'b00));

  assert_read_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_kind == 4'h8 || req_kind == 4'h9)) |-> (req_strb == 4'hF));
endmodule

bind cfg_pio_engine cfg_pio_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_kind(req_kind), .req_addr_lo(req_addr_lo), .req_addr_hi(req_addr_hi),
  .req_wdata(req_wdata), .req_strb(req_strb), .req_win_bypass(req_win_bypass),
  .cpl_ready(cpl_ready)
);

// File: tb/sim_cfg_pio_engine.sv
`timescale 1ns/1ps
module sim_cfg_pio_engine;
  localparam int unsigned AW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        req_valid, req_ready = 1'b0;
  logic [3:0]  req_kind, req_strb;
  logic [31:0] req_addr_lo, req_addr_hi, req_wdata;
  logic        req_win_bypass;
  logic        cpl_valid = 1'b0, cpl_ready;
  logic [2:0]  cpl_status = '0;
  logic [31:0] cpl_data = '0;
  logic        irq;

  always #2 clk = ~clk;

  cfg_pio_engine #(.ADDR_W(AW)) u0 (.*);

  typedef struct packed {
    logic [3:0] kind; logic byp; logic [31:0] alo, ahi, wd; logic [3:0] strb;
  } exp_t;

  exp_t exp_q[$];
  int   vecs = 0, bad = 0, hs_count = 0;
  int   stall_cfg = 0, lat_cfg = 0, stall_left = 0, lat_left = 0;
  logic [2:0]  stub_st = 0;
  logic [31:0] stub_data = 0;
  bit   pending = 0, cpl_going = 0, finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // downstream stub and scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      req_ready = 0; cpl_valid = 0; pending = 0; cpl_going = 0;
    end else begin
      if (cpl_going) begin cpl_valid = 0; cpl_going = 0; end
      if (req_valid && !pending) begin
        if (stall_left > 0) begin
          req_ready = 0; stall_left--;
        end else begin
          req_ready = 1;
        end
      end else req_ready = 0;
      if (req_valid && req_ready) begin
        exp_t got, e;
        got = '{req_kind, req_win_bypass, req_addr_lo, req_addr_hi, req_wdata, req_strb};
        hs_count++;
        vecs++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R9 act=extra request %h exp=none", got);
        end else begin
          e = exp_q.pop_front();
          if (got !== e) begin
            bad++;
            $display("FAIL R2/R4/R5 act=%h exp=%h", got, e);
          end
        end
        pending = 1; lat_left = lat_cfg; stall_left = stall_cfg;
      end else if (pending && !cpl_valid) begin
        if (lat_left > 0) lat_left--;
        else begin
          cpl_valid = 1; cpl_status = stub_st; cpl_data = stub_data;
        end
      end
      if (cpl_valid && cpl_ready && !cpl_going) begin
        cpl_going = 1; pending = 0;
      end
    end
  end

  task automatic bwr(input int unsigned a, input logic [31:0] d);
    bus_addr = AW'(a); bus_wdata = d; bus_wr_en = 1;
    @(negedge clk);
    bus_wr_en = 0;
  endtask

  task automatic brd(input int unsigned a, output logic [31:0] d);
    bus_addr = AW'(a);
    #0.5;
    d = bus_rdata;
  endtask

  task automatic issue(input logic [3:0] kind, input logic byp, input logic [31:0] alo,
                       input logic [31:0] ahi, input logic [31:0] wd, input logic [3:0] strb);
    exp_t e;
    bwr('h00, {7'b0, byp, 20'b0, kind});
    bwr('h08, alo);
    bwr('h0C, ahi);
    bwr('h10, wd);
    bwr('h14, {28'b0, strb});
    e = '{kind, byp, {alo[31:2], 2'b00}, ahi, wd,
          (kind == 4'h8 || kind == 4'h9) ? 4'hF : strb};
    exp_q.push_back(e);
    bwr('h1C, 32'h1);
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      brd('h20, v);
      if (v[0]) return;
      @(negedge clk);
    end
    check("R6 done timeout", 0, 1);
  endtask

  function automatic logic [31:0] cfg_addr(input logic [7:0] b, input logic [4:0] d,
                                           input logic [2:0] f, input logic [11:0] r);
    return {4'b0, b, d, f, r};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; vecs++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int hs0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    brd('h1C, v); check("R1 start", v, 0);
    brd('h20, v); check("R1 done", v, 0);
    brd('h24, v); check("R1 mask", v, 1);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 req_valid", {31'b0, req_valid}, 0);

    // R12 control readback
    bwr('h00, 32'hFFFF_FFFF);
    brd('h00, v); check("R12 ctrl readback", v, 32'h0100_000F);

    // type-0 read, low address bits set, odd strobe
    stall_cfg = 0; lat_cfg = 2; stub_st = 0; stub_data = 32'h1234_5678;
    issue(4'h8, 1'b1, cfg_addr(8'h3C, 5'h1B, 3'h5, 12'h0AB), 32'h0, 32'h0, 4'h3);
    @(negedge clk);
    brd('h1C, v); check("R2 start busy", v, 1);
    wait_done();
    brd('h1C, v); check("R6 start cleared", v, 0);
    brd('h04, v); check("R6 R8 status ok np", v, 32'h1);
    brd('h18, v); check("R7 read data", v, 32'h1234_5678);

    // R10 / R11 done and irq
    bwr('h20, 32'h0);
    brd('h20, v); check("R10 write0 keeps done", v, 1);
    check("R11 masked irq", {31'b0, irq}, 0);
    bwr('h24, 32'h0);
    check("R11 unmasked irq", {31'b0, irq}, 1);
    bwr('h20, 32'h1);
    brd('h20, v); check("R10 w1c done", v, 0);
    check("R11 irq after clear", {31'b0, irq}, 0);

    // type-1 write, 16-bit at byte offset 2, back-pressure, UR status
    stall_cfg = 3; stall_left = 3; lat_cfg = 1; stub_st = 3'd1; stub_data = 32'hDEAD_DEAD;
    issue(4'hB, 1'b0, cfg_addr(8'h02, 5'h04, 3'h1, 12'h012), 32'h0000_0007,
          32'hBEEF << 16, 4'b0011 << 2);
    wait_done();
    brd('h04, v); check("R6 R8 status UR np", v, (32'd1 << 7) | 32'h1);
    brd('h18, v); check("R7 write keeps rdata", v, 32'h1234_5678);
    check("R11 irq unmasked done", {31'b0, irq}, 1);
    bwr('h20, 32'h1);

    // R9 start while outstanding
    stall_cfg = 0; stall_left = 0; lat_cfg = 12; stub_st = 3'd2; stub_data = 32'hA5A5_0F0F;
    hs0 = hs_count;
    issue(4'h9, 1'b0, cfg_addr(8'hFF, 5'h1F, 3'h7, 12'hFFC), 32'h0, 32'h0, 4'h0);
    repeat (3) @(negedge clk);
    bwr('h1C, 32'h1);
    brd('h1C, v); check("R9 start still busy", v, 1);
    wait_done();
    repeat (20) @(negedge clk);
    check("R9 one request", hs_count - hs0, 1);
    brd('h04, v); check("R6 status retry", v, (32'd2 << 7) | 32'h1);
    brd('h18, v); check("R7 type1 read data", v, 32'hA5A5_0F0F);
    bwr('h20, 32'h1);

    // non-configuration kind: posted, strobe passed as programmed
    lat_cfg = 0; stub_st = 3'd4; stub_data = 32'h0BAD_F00D;
    issue(4'h4, 1'b1, 32'h0000_1003, 32'h0000_0001, 32'hCAFE_0001, 4'h5);
    wait_done();
    brd('h04, v); check("R6 R8 status abort posted", v, 32'd4 << 7);
    brd('h18, v); check("R7 non-read keeps rdata", v, 32'hA5A5_0F0F);
    bwr('h20, 32'h1);
    bwr('h24, 32'h1);
    check("R11 irq low", {31'b0, irq}, 0);
    check("R3 queue drained", exp_q.size(), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule